// File: doc/BRIEF.md
# Signed/Unsigned Multiplier Built on an Unsigned Core

This block multiplies two N-bit operands and returns the full 2N-bit product. A single mode input chooses how the operands are read: as plain unsigned numbers, or as two's complement numbers. Only an unsigned multiplier array is ever used. Signed results come from a correction applied to the upper half of the unsigned product.

In signed mode the most significant bit of an operand weighs -2^(N-1) rather than +2^(N-1). Its signed value is therefore its unsigned reading less 2^N. The correction follows from this. When A is negative, B is subtracted from the upper half. When B is negative, A is subtracted from the upper half. Both subtractions are made when both operands are negative, and all of this arithmetic is modulo 2^N. The block never takes an absolute value and never negates the product, and the lower half of the product is left as it is.

A caller presents the operands and the mode together with a one-cycle strobe. The product and a matching valid flag appear on the next clock edge and hold until the next strobe.

Top module: `smul_top`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released until the first strobe, out_valid is 0 and product is 0.
- R2: out_valid is 1 in the cycle that follows a clock edge at which in_valid was 1, and 0 after an edge at which in_valid was 0.
- R3: With signed_mode = 0, product equals the unsigned product of op_a and op_b, zero-extended to 2N bits.
- R4: With signed_mode = 1, product equals the two's complement product of op_a and op_b. The operands' top bits weigh -2^(N-1), and the result is a 2N-bit two's complement value.
- R5: The lower N bits of product are identical for a given operand pair in both modes.
- R6: With signed_mode = 1 and exactly one operand negative, the upper half of product equals the unsigned upper half minus the other operand, modulo 2^N.
- R7: With signed_mode = 1 and both operands negative, both subtractions are applied to the upper half. For example, 0xFF × 0xFF gives 0x0001.
- R8: In signed mode, the most negative value times itself gives the positive value 2^(2N-2), with a top bit of 0 (0x4000 for N = 8).
- R9: When in_valid is 0 at an edge, product keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: operands and mode are captured at this edge |
| signed_mode | input | 1 | 1 reads the operands as two's complement, 0 as unsigned |
| op_a | input | N | Operand A |
| op_b | input | N | Operand B |
| out_valid | output | 1 | High for one cycle after each strobe |
| product | output | 2N | Registered double-width product |

## Verification
A fault in the correction flags or the subtraction shows up only in the upper half of product. It appears in the cycle right after the strobe, and only for operand pairs whose sign bits are set in signed mode. Unsigned vectors therefore cannot expose it, and the bench mixes one-negative, two-negative and most-negative cases. A fault in the partial-product array also disturbs the lower half, which must match between the two modes. A bad output register shows up as a valid flag that lingers, or as a product that drifts between strobes.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic {
    MODE_UNS = 1'b0,
    MODE_SGN = 1'b1
  } smul_mode_e;
endpackage

// File: rtl/smul_pp_array.sv
module smul_pp_array #(
  parameter int N = 8
) (
  input  logic [N-1:0]   mul_a,
  input  logic [N-1:0]   mul_b,
  output logic [2*N-1:0] uprod
);
  localparam int W = 2 * N;

  logic [W-1:0] row  [N];
  logic [W-1:0] psum [N+1];

  assign psum[0] = '0;

  for (genvar g = 0; g < N; g++) begin : g_row
    assign row[g]    = mul_b[g] ? ({{N{1'b0}}, mul_a} << g) : '0;
    assign psum[g+1] = psum[g] + row[g];
  end

  assign uprod = psum[N];
endmodule

// File: rtl/smul_hi_fix.sv
module smul_hi_fix
  import smul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [2*N-1:0] uprod,
  input  logic [N-1:0]   fix_a,
  input  logic [N-1:0]   fix_b,
  input  smul_mode_e     mode,
  output logic           corr_a,
  output logic           corr_b,
  output logic [2*N-1:0] sprod
);
  localparam int W = 2 * N;

  function automatic logic [N-1:0] hi_adjust(
    input logic [N-1:0] hi,
    input logic [N-1:0] a,
    input logic [N-1:0] b,
    input logic         ca,
    input logic         cb
  );
    logic [N-1:0] t;
    t = hi;
    if (ca) t = t - b;
    if (cb) t = t - a;
    return t;
  endfunction

  assign corr_a = (mode == MODE_SGN) && fix_a[N-1];
  assign corr_b = (mode == MODE_SGN) && fix_b[N-1];

  assign sprod = {hi_adjust(uprod[W-1:N], fix_a, fix_b, corr_a, corr_b),
                  uprod[N-1:0]};
endmodule

// File: rtl/smul_top.sv
module smul_top
  import smul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           signed_mode,
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic           out_valid,
  output logic [2*N-1:0] product
);
  localparam int W = 2 * N;

  logic [W-1:0] uprod;
  logic [W-1:0] sprod;
  logic         corr_a;
  logic         corr_b;
  smul_mode_e   mode;

  assign mode = smul_mode_e'(signed_mode);

  smul_pp_array #(.N(N)) pp_i (
    .mul_a (op_a),
    .mul_b (op_b),
    .uprod (uprod)
  );

  smul_hi_fix #(.N(N)) fix_i (
    .uprod  (uprod),
    .fix_a  (op_a),
    .fix_b  (op_b),
    .mode   (mode),
    .corr_a (corr_a),
    .corr_b (corr_b),
    .sprod  (sprod)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= sprod;
    end
  end
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           signed_mode,
  input logic [N-1:0]   op_a,
  input logic [N-1:0]   op_b,
  input logic           corr_a,
  input logic           corr_b,
  input logic           out_valid,
  input logic [2*N-1:0] product
);
  localparam int W = 2 * N;

  logic [W-1:0] ref_u;
  logic [N-1:0] ref_hi;
  logic [N-1:0] ref_lo;
  logic [N-1:0] min_val;

  assign ref_u   = {{N{1'b0}}, op_a} * {{N{1'b0}}, op_b};
  assign ref_hi  = ref_u[W-1:N];
  assign ref_lo  = ref_u[N-1:0];
  assign min_val = {1'b1, {(N-1){1'b0}}};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_UNSIGNED_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !signed_mode) |=> product == $past(ref_u)); // R3
  AST_SIGN_OF_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && signed_mode && op_a != '0 && op_b != '0)
      |=> product[W-1] == $past(op_a[N-1] ^ op_b[N-1])); // R4
  AST_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> product[N-1:0] == $past(ref_lo)); // R5
  AST_ONE_FIX_A: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && corr_a && !corr_b)
      |=> product[W-1:N] == $past(ref_hi - op_b)); // R6
  AST_TWO_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && corr_a && corr_b)
      |=> product[W-1:N] == $past(ref_hi - op_b - op_a)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && signed_mode && op_a == min_val && op_b == min_val)
      |=> product == (W'(1) << (W - 2))); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product)); // R9
endmodule

bind smul_top smul_chk #(.N(N)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .signed_mode (signed_mode),
  .op_a        (op_a),
  .op_b        (op_b),
  .corr_a      (corr_a),
  .corr_b      (corr_b),
  .out_valid   (out_valid),
  .product     (product)
);

// File: tb/smul_top_tb_top.sv
`timescale 1ns/1ps
module smul_top_tb_top;
  localparam int N = 8;
  localparam int W = 2 * N;
  localparam int NV = 13;

  // entry: {mode, a, b, expected}
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 8'h03, 8'h05, 16'h000F},
    {1'b0, 8'hFF, 8'hFF, 16'hFE01},
    {1'b1, 8'hFF, 8'hFF, 16'h0001},
    {1'b1, 8'h80, 8'h80, 16'h4000},
    {1'b0, 8'h80, 8'h80, 16'h4000},
    {1'b1, 8'hFE, 8'h03, 16'hFFFA},
    {1'b1, 8'h05, 8'hF9, 16'hFFDD},
    {1'b1, 8'h7F, 8'h80, 16'hC080},
    {1'b0, 8'h7F, 8'h80, 16'h3F80},
    {1'b1, 8'h00, 8'h80, 16'h0000},
    {1'b1, 8'h64, 8'h9C, 16'hD8F0},
    {1'b0, 8'h64, 8'h9C, 16'h3CF0},
    {1'b1, 8'h7F, 8'h7F, 16'h3F01}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         signed_mode = 1'b0;
  logic [N-1:0] op_a = '0;
  logic [N-1:0] op_b = '0;
  logic         out_valid;
  logic [W-1:0] product;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  smul_top #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .signed_mode(signed_mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic m, input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    signed_mode = m; op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [W-1:0] lo_u;
    logic [W-1:0] held;
    logic signed [W-1:0] sref;
    #35;
    chk("R1 valid in reset", W'(out_valid), '0);
    chk("R1 product in reset", product, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 valid after reset", W'(out_valid), '0);
    chk("R1 product after reset", product, '0);

    // R3 R4 R6 R7 R8 table
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][32], VEC[i][31:24], VEC[i][23:16]);
      chk("R2 valid after strobe", W'(out_valid), W'(1));
      chk(VEC[i][32] ? "R4 R6 R7 R8 signed vector" : "R3 unsigned vector",
          product, VEC[i][15:0]);
    end

    // R2 R9: no strobe -> valid low, product held
    held = product;
    @(negedge clk);
    chk("R2 valid drops", W'(out_valid), '0);
    op_a = 8'h11; op_b = 8'h22; signed_mode = 1'b1;
    @(negedge clk);
    chk("R9 product held", product, held);

    // R4 sweep against bench signed product
    for (int a = -128; a < 128; a += 37) begin
      for (int b = -128; b < 128; b += 29) begin
        sref = W'(a * b);
        run_op(1'b1, N'(a), N'(b));
        chk("R4 signed sweep", product, sref);
      end
    end

    // R5: low half equal across modes
    for (int k = 0; k < 4; k++) begin
      run_op(1'b0, N'(8'h9B + k * 41), N'(8'hC7 - k * 23));
      lo_u = {8'h00, product[N-1:0]};
      run_op(1'b1, N'(8'h9B + k * 41), N'(8'hC7 - k * 23));
      chk("R5 low half match", {8'h00, product[N-1:0]}, lo_u);
    end

    // R6: only B negative, hi = uhi - A
    run_op(1'b1, 8'h09, 8'hF0);
    chk("R6 single correction", {8'h00, product[W-1:N]},
        {8'h00, 8'(((16'h0009 * 16'h00F0) >> 8) - 16'h0009)});

    // R8 again, then reset mid-run clears
    run_op(1'b1, 8'h80, 8'h80);
    chk("R8 min squared sign", W'(product[W-1]), '0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears", product, '0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule